// File: doc/BRIEF.md
# Floating-Point Divide/Square-Root Occupancy Controller

This block tracks the timing of a non-pipelined floating-point divide and square-root unit. It does no arithmetic. The unit shares the floating-point multiplier with the rest of the pipeline. It takes the multiplier in the cycle the operation issues, and again for one rounding cycle near the end. The controller tells the issue logic four things: when the divider is occupied, exactly which cycles the multiplier is taken, when a dependent add or multiply may already pick up the result, and when the result is final.

Requests arrive on a valid/ready pair. `req_ready` is high whenever no operation is in flight. A request is taken on a clock edge where `req_valid`, `req_ready` and `req_lead` are all high. `req_lead` marks an instruction that opens its dispatch group, and only such an instruction may start the unit. A request that is not taken is dropped, not held or queued. In that cycle `req_stall` is raised so that the issue logic can hold the instruction and present it again later.

Cycle numbering below counts the issue cycle, where the request is taken, as cycle 0. L is the total latency: 13 for single precision (`req_dbl` = 0) and 23 for double precision (`req_dbl` = 1).

Top module: `fdiv_occupancy_ctrl`

## Requirements
- R1: During and right after reset, `busy`, `res_valid`, `mul_claim`, `mul_steal_next`, `fwd_ready` and `req_stall` are low, and `req_ready` is high.
- R2: A request is taken when `req_valid`, `req_lead` and `req_ready` are high together. `busy` rises in the following cycle.
- R3: For a single-precision request (`req_dbl` = 0), `busy` is high in cycles 1 through 12.
- R4: For a double-precision request (`req_dbl` = 1), `busy` is high in cycles 1 through 22.
- R5: `mul_claim` is high in the issue cycle, combinationally from the request that is taken, and in the rounding cycle L-4 (cycle 9 or 19). It is low in every other cycle.
- R6: `mul_steal_next` is high only in cycle L-5 (cycle 8 or 18), one cycle before the rounding cycle.
- R7: `fwd_ready` is high only in cycle L-1 (cycle 12 or 22), the first cycle in which a dependent add or multiply may issue.
- R8: A request that arrives while `busy` is high raises `req_stall`. It does not disturb the timing of the operation in flight, and it does not change the precision reported at completion. While `busy` is high, `req_ready` is low.
- R9: A request with `req_lead` low is refused even when the unit is idle. `req_stall` is high, `mul_claim` stays low, and `busy` stays low in the next cycle.
- R10: `res_valid` is high for exactly cycle L, and `busy` is low in that same cycle. During `res_valid`, `res_dbl` shows the precision of the finishing operation. A new request may be taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Divide/square-root start request |
| req_dbl | input | 1 | Precision of the request: 1 = double, 0 = single |
| req_lead | input | 1 | Request is the first instruction of its dispatch group |
| req_ready | output | 1 | Unit idle; a leading request would be taken |
| req_stall | output | 1 | Request present this cycle but refused |
| busy | output | 1 | Operation in flight |
| mul_claim | output | 1 | Shared multiplier taken this cycle |
| mul_steal_next | output | 1 | Multiplier will be taken for rounding next cycle |
| fwd_ready | output | 1 | Dependent add/multiply may issue this cycle |
| res_valid | output | 1 | Result final, one-cycle strobe |
| res_dbl | output | 1 | Precision of the finishing operation |

## Verification
Each operation is walked cycle by cycle in both precisions, and every output is compared against windows derived from the latency. This separates an error in the single-precision timing from one in the double-precision timing. A second request is then injected at every cycle offset inside each operation, using the opposite precision. This shows whether a refused request can restart, shorten or reclassify the operation in flight. Back-to-back requests presented in the completion cycle check that a new operation starts there, and a non-leading request at idle checks that the group-position rule is enforced.

// File: rtl/fdiv_occ_pkg.sv
package fdiv_occ_pkg;

  typedef enum logic {
    PREC_SP = 1'b0,
    PREC_DP = 1'b1
  } prec_e;

  // Per-cycle event flags decoded from the progress counter.
  typedef struct packed {
    logic round_claim;  // multiplier taken for rounding
    logic steal_next;   // rounding claim happens next cycle
    logic fwd;          // early forwarding cycle
    logic last;         // final busy cycle
  } window_t;

endpackage

// File: rtl/fdiv_issue_gate.sv
module fdiv_issue_gate (
  input  logic req_valid,
  input  logic req_lead,
  input  logic busy,
  output logic req_ready,
  output logic accept,
  output logic req_stall
);

  always_comb begin
    req_ready = ~busy;
    accept    = req_valid & req_lead & ~busy;
    req_stall = req_valid & ~accept;
  end

endmodule

// File: rtl/fdiv_window_decode.sv
module fdiv_window_decode
  import fdiv_occ_pkg::*;
#(
  parameter int CW         = 5,
  parameter int LAT_SP     = 13,
  parameter int LAT_DP     = 23,
  parameter int ROUND_LEAD = 4,
  parameter int FWD_LEAD   = 1
) (
  input  logic [CW-1:0] cnt,
  input  prec_e         prec,
  output window_t       win
);

  window_t per_prec [2];

  for (genvar p = 0; p < 2; p++) begin : g_prec
    localparam int LAT       = (p == 0) ? LAT_SP : LAT_DP;
    localparam int ROUND_CYC = LAT - ROUND_LEAD;
    localparam int FWD_CYC   = LAT - FWD_LEAD;
    localparam int LAST_CYC  = LAT - 1;

    always_comb begin
      per_prec[p].round_claim = (cnt == CW'(ROUND_CYC));
      per_prec[p].steal_next  = (cnt == CW'(ROUND_CYC - 1));
      per_prec[p].fwd         = (cnt == CW'(FWD_CYC));
      per_prec[p].last        = (cnt == CW'(LAST_CYC));
    end
  end

  always_comb begin
    win = (prec == PREC_DP) ? per_prec[1] : per_prec[0];
  end

endmodule

// File: rtl/fdiv_seq_counter.sv
module fdiv_seq_counter
  import fdiv_occ_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  prec_e         start_prec,
  input  logic          last,
  output logic [CW-1:0] cnt,
  output prec_e         prec,
  output logic          busy,
  output logic          done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      prec <= PREC_SP;
      done <= 1'b0;
    end else begin
      done <= busy & last;
      if (start) begin
        cnt  <= CW'(1);
        prec <= start_prec;
      end else if (busy) begin
        cnt <= last ? '0 : cnt + CW'(1);
      end
    end
  end

  always_comb busy = (cnt != '0);

endmodule

// File: rtl/fdiv_occupancy_ctrl.sv
module fdiv_occupancy_ctrl
  import fdiv_occ_pkg::*;
#(
  parameter int LAT_SP     = 13,
  parameter int LAT_DP     = 23,
  parameter int ROUND_LEAD = 4,
  parameter int FWD_LEAD   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_dbl,
  input  logic req_lead,
  output logic req_ready,
  output logic req_stall,
  output logic busy,
  output logic mul_claim,
  output logic mul_steal_next,
  output logic fwd_ready,
  output logic res_valid,
  output logic res_dbl
);

  localparam int MAX_LAT = (LAT_DP > LAT_SP) ? LAT_DP : LAT_SP;
  localparam int CW      = $clog2(MAX_LAT + 1);

  logic          accept;
  logic [CW-1:0] cnt;
  prec_e         prec;
  window_t       win;

  fdiv_issue_gate u_gate (
    .req_valid (req_valid),
    .req_lead  (req_lead),
    .busy      (busy),
    .req_ready (req_ready),
    .accept    (accept),
    .req_stall (req_stall)
  );

  fdiv_seq_counter #(.CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_prec (prec_e'(req_dbl)),
    .last       (win.last),
    .cnt        (cnt),
    .prec       (prec),
    .busy       (busy),
    .done       (res_valid)
  );

  fdiv_window_decode #(
    .CW         (CW),
    .LAT_SP     (LAT_SP),
    .LAT_DP     (LAT_DP),
    .ROUND_LEAD (ROUND_LEAD),
    .FWD_LEAD   (FWD_LEAD)
  ) u_win (
    .cnt  (cnt),
    .prec (prec),
    .win  (win)
  );

  always_comb begin
    mul_claim      = accept | (busy & win.round_claim);
    mul_steal_next = busy & win.steal_next;
    fwd_ready      = busy & win.fwd;
    res_dbl        = (prec == PREC_DP);
  end

endmodule

// File: rtl/fdiv_occupancy_ctrl_chk.sv
module fdiv_occupancy_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_lead,
  input logic req_stall,
  input logic busy,
  input logic mul_claim,
  input logic mul_steal_next,
  input logic fwd_ready,
  input logic res_valid
);

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lead && !busy) |=> busy);

  assert_stall_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |-> req_stall);

  assert_lead_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_lead && !busy) |=> !busy);

  assert_steal_then_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mul_steal_next |=> (mul_claim && busy));

  assert_fwd_then_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_ready |=> res_valid);

  assert_res_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_res_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (!busy && $past(busy)));

endmodule

bind fdiv_occupancy_ctrl fdiv_occupancy_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_lead       (req_lead),
  .req_stall      (req_stall),
  .busy           (busy),
  .mul_claim      (mul_claim),
  .mul_steal_next (mul_steal_next),
  .fwd_ready      (fwd_ready),
  .res_valid      (res_valid)
);

// File: tb/fdiv_occupancy_ctrl_tb.sv
module fdiv_occupancy_ctrl_tb;

  localparam int LSP = 13;
  localparam int LDP = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_dbl = 1'b0;
  logic req_lead = 1'b0;
  logic req_ready, req_stall, busy, mul_claim, mul_steal_next;
  logic fwd_ready, res_valid, res_dbl;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fdiv_occupancy_ctrl u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_dbl        (req_dbl),
    .req_lead       (req_lead),
    .req_ready      (req_ready),
    .req_stall      (req_stall),
    .busy           (busy),
    .mul_claim      (mul_claim),
    .mul_steal_next (mul_steal_next),
    .fwd_ready      (fwd_ready),
    .res_valid      (res_valid),
    .res_dbl        (res_dbl)
  );

  task automatic chk(string tag, string what, int cyc, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%0b expected=%0b", tag, what, cyc, act, exp);
    end
  endtask

  // One operation, cycle 0 = issue cycle. ik = cycle of an extra request
  // (opposite precision), nxt = new request in the completion cycle.
  task automatic run_op(bit dbl, bit skip0, int ik, bit nxt, bit ndbl);
    int lat;
    string tb_t;
    lat  = dbl ? LDP : LSP;
    tb_t = dbl ? "R4" : "R3";
    for (int k = (skip0 ? 1 : 0); k <= lat; k++) begin
      bit drive;
      bit exp_busy;
      @(negedge clk);
      drive     = (k == 0) || (k == ik) || (k == lat && nxt);
      req_valid = drive;
      req_dbl   = (k == 0) ? dbl : ((k == lat) ? ndbl : ~dbl);
      req_lead  = 1'b1;
      #1;
      exp_busy = (k >= 1) && (k <= lat - 1);
      chk(tb_t,  "busy",           k, busy,           exp_busy);
      chk("R10", "res_valid",      k, res_valid,      k == lat);
      if (k == lat) chk("R10", "res_dbl", k, res_dbl, dbl);
      chk("R5",  "mul_claim",      k, mul_claim,
          (k == 0) || (k == lat - 4) || (k == lat && nxt));
      chk("R6",  "mul_steal_next", k, mul_steal_next, k == lat - 5);
      chk("R7",  "fwd_ready",      k, fwd_ready,      k == lat - 1);
      chk("R8",  "req_stall",      k, req_stall,      drive && exp_busy);
      chk("R8",  "req_ready",      k, req_ready,      !exp_busy);
      if (k == 1 && !skip0) chk("R2", "busy_rise", k, busy, 1'b1);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busy",           0, busy,           1'b0);
    chk("R1", "res_valid",      0, res_valid,      1'b0);
    chk("R1", "mul_claim",      0, mul_claim,      1'b0);
    chk("R1", "mul_steal_next", 0, mul_steal_next, 1'b0);
    chk("R1", "fwd_ready",      0, fwd_ready,      1'b0);
    chk("R1", "req_stall",      0, req_stall,      1'b0);
    chk("R1", "req_ready",      0, req_ready,      1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    // R9: non-leading request at idle is refused
    @(negedge clk);
    req_valid = 1'b1; req_lead = 1'b0; req_dbl = 1'b1;
    #1;
    chk("R9", "req_stall", 0, req_stall, 1'b1);
    chk("R9", "mul_claim", 0, mul_claim, 1'b0);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R9", "busy", 1, busy, 1'b0);

    // Plain operations, then an intruding request at every offset
    for (int d = 0; d < 2; d++) begin
      int lat;
      lat = (d == 1) ? LDP : LSP;
      run_op(d[0], 1'b0, -1, 1'b0, 1'b0);
      for (int ik = 1; ik < lat; ik++) run_op(d[0], 1'b0, ik, 1'b0, 1'b0);
    end

    // R10: back-to-back starts in the completion cycle
    run_op(1'b0, 1'b0, -1, 1'b1, 1'b1);
    run_op(1'b1, 1'b1, -1, 1'b1, 1'b0);
    run_op(1'b0, 1'b1, -1, 1'b0, 1'b0);

    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk("R10", "idle_after_chain", 0, busy, 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule